// File: doc/BRIEF.md
# Audio Source Routing and Mute Controller

This block turns a set of configuration fields into select codes and enable flags for the analog switches of a television sound processor. It serves three outputs: loudspeakers, headphones and the SCART output. For each output it gives one select code for the left channel and one for the right channel, plus one enable flag.

Source selection follows a fixed priority chain. SCART playback wins over the AM input, the AM input wins over the direct (bypass) inputs, and the bypass wins over the matrix mode. The matrix mode can be forced to mono, stereo or dual. It can also be set to automatic, in which case it follows the status reported by the identification decoder. The sound 1 / sound 2 switches of each output take effect only while the effective mode is dual.

A configuration word is captured when `cfg_load` is high. All select codes and enables are registered. They change exactly one clock after a load, or one clock after the decoder status changes, so no combinational glitch reaches the switches.

Top module: `audio_route_ctrl`

## Requirements
- R1: When the master enable `cfg_mute_all_n` is 0, all three enables `spk_live`, `hp_live` and `scart_live` are 0.
- R2: When the master enable is 1, `hp_live` is 1, `spk_live` equals `cfg_spk_on`, and `scart_live` equals `cfg_scart_on`.
- R3: Loudspeaker and headphone sources follow the priority SCART playback > AM > bypass > matrix mode. SCART playback does not change the SCART output. The select codes are: sound 1 = 0, sound 2 = 1, dematrixed left = 2, dematrixed right = 3, direct left = 4, direct right = 5, AM = 6, SCART-in left = 7, SCART-in right = 8.
- R4: The matrix field is encoded 00 mono, 01 stereo, 10 dual, 11 automatic. In mono, every channel selects sound 1 (code 0). In stereo, left selects code 2 and right selects code 3. In dual, both channels of the loudspeakers select sound 2 when `cfg_spk_snd2` is 1 and sound 1 otherwise; the headphones follow `cfg_hp_snd2` in the same way. Outside dual mode these two bits have no effect.
- R5: In automatic mode, decoder status 01 gives stereo, 10 gives dual, and 00 or 11 gives mono.
- R6: In dual mode, with no higher-priority source active, the SCART output map code gives (left, right) = (sound 1, sound 2) for 00, (sound 2, sound 2) for 01, (sound 1, sound 1) for 10, and (sound 2, sound 1) for 11. Outside dual mode the map has no effect.
- R7: With SCART playback active and its channel switch `cfg_scart_chsw` at 0, the loudspeakers and headphones select left code 7 and right code 8. With the channel switch at 1, both channels of each output select code 8 if that output's sound 2 bit is 1, and code 7 otherwise.
- R8: With `cfg_am` at 1, the AM source (code 6) takes priority over bypass. With AM at 0 and `cfg_bypass` at 1, left selects code 4 and right selects code 5. Both apply to all three outputs, subject to R3.
- R9: Outputs change one clock after a `cfg_load` pulse and one clock after a change of `id_status`. Configuration inputs are ignored while `cfg_load` is 0.
- R10: After reset, all enables are 0 and every select code is 6 (AM). The held configuration has the master enable at 0, the loudspeaker enable at 0, the SCART enable at 1, AM at 1, bypass at 1 and matrix mono.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Capture the configuration inputs |
| cfg_mute_all_n | input | 1 | Master enable for all outputs |
| cfg_spk_on | input | 1 | Loudspeaker enable |
| cfg_scart_on | input | 1 | SCART output enable |
| cfg_spk_snd2 | input | 1 | Loudspeakers take sound 2 in dual mode |
| cfg_hp_snd2 | input | 1 | Headphones take sound 2 in dual mode |
| cfg_scart_play | input | 1 | SCART inputs feed loudspeakers and headphones |
| cfg_scart_chsw | input | 1 | Channel switch enable during SCART playback |
| cfg_am | input | 1 | Select the AM input |
| cfg_bypass | input | 1 | Route the direct inputs past the matrix |
| cfg_matrix | input | 2 | Matrix mode (mono, stereo, dual, automatic) |
| cfg_scart_map | input | 2 | SCART output channel map in dual mode |
| id_status | input | 2 | Identification decoder status |
| spk_l_sel | output | 4 | Loudspeaker left select code |
| spk_r_sel | output | 4 | Loudspeaker right select code |
| hp_l_sel | output | 4 | Headphone left select code |
| hp_r_sel | output | 4 | Headphone right select code |
| scart_l_sel | output | 4 | SCART output left select code |
| scart_r_sel | output | 4 | SCART output right select code |
| spk_live | output | 1 | Loudspeaker output enabled |
| hp_live | output | 1 | Headphone output enabled |
| scart_live | output | 1 | SCART output enabled |

## Verification
The bench moves through the matrix modes with the higher-priority sources cleared. This separates mono, stereo and dual, and shows that the sound 2 bits act only in dual. It then turns on SCART playback, AM and bypass in combinations: AM together with bypass, and playback together with AM. Each combination tells one rung of the priority chain from the rung below it. It also checks that the SCART output ignores playback.

Automatic mode is driven by changing the decoder status alone, with no load pulse. This separates decoder-driven updates from configuration-driven ones. The inhibited status code checks the mono fallback.

Master enable and per-output enable patterns are applied in layered combinations. Load timing is checked both in the cycle of the load and in the cycle after it, and input changes are applied without a load to show they are ignored.

// File: rtl/audio_route_pkg.sv
package audio_route_pkg;

    localparam int SEL_W    = 4;
    localparam int MODE_W   = 2;
    localparam int NUM_PROG = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_SND1    = 4'd0,
        SRC_SND2    = 4'd1,
        SRC_MTX_L   = 4'd2,
        SRC_MTX_R   = 4'd3,
        SRC_RAW_L   = 4'd4,
        SRC_RAW_R   = 4'd5,
        SRC_AM      = 4'd6,
        SRC_SCART_L = 4'd7,
        SRC_SCART_R = 4'd8
    } src_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_MONO   = 2'b00,
        MODE_STEREO = 2'b01,
        MODE_DUAL   = 2'b10,
        MODE_AUTO   = 2'b11
    } mode_e;

    typedef struct packed {
        logic              mute_all_n;
        logic              spk_on;
        logic              scart_on;
        logic              spk_snd2;
        logic              hp_snd2;
        logic              scart_play;
        logic              scart_chsw;
        logic              am;
        logic              bypass;
        logic [MODE_W-1:0] matrix;
        logic [1:0]        scart_map;
    } cfg_t;

    typedef struct packed {
        src_e l;
        src_e r;
    } pair_t;

    typedef struct packed {
        pair_t spk;
        pair_t hp;
        pair_t sct;
        logic  spk_live;
        logic  hp_live;
        logic  sct_live;
    } route_t;

    typedef struct packed {
        cfg_t   cfg;
        route_t out;
    } state_t;

    localparam cfg_t CFG_RESET = '{
        mute_all_n: 1'b0, spk_on: 1'b0, scart_on: 1'b1,
        spk_snd2: 1'b0, hp_snd2: 1'b0, scart_play: 1'b0,
        scart_chsw: 1'b0, am: 1'b1, bypass: 1'b1,
        matrix: 2'b00, scart_map: 2'b00
    };

    localparam route_t ROUTE_RESET = '{
        spk: '{l: SRC_AM, r: SRC_AM},
        hp:  '{l: SRC_AM, r: SRC_AM},
        sct: '{l: SRC_AM, r: SRC_AM},
        spk_live: 1'b0, hp_live: 1'b0, sct_live: 1'b0
    };

endpackage

// File: rtl/audio_route_mode.sv
module audio_route_mode
    import audio_route_pkg::*;
(
    input  logic [MODE_W-1:0] matrix,
    input  logic [1:0]        id_status,
    output logic [MODE_W-1:0] eff_mode
);
    always_comb begin
        if (matrix == MODE_AUTO) begin
            case (id_status)
                2'b01:   eff_mode = MODE_STEREO;
                2'b10:   eff_mode = MODE_DUAL;
                default: eff_mode = MODE_MONO;
            endcase
        end else begin
            eff_mode = matrix;
        end
    end
endmodule

// File: rtl/audio_route_prog.sv
module audio_route_prog
    import audio_route_pkg::*;
(
    input  logic              scart_play,
    input  logic              scart_chsw,
    input  logic              am,
    input  logic              bypass,
    input  logic [MODE_W-1:0] eff_mode,
    input  logic              snd2,
    output pair_t             sel
);
    always_comb begin
        sel = '{l: SRC_SND1, r: SRC_SND1};
        if (scart_play) begin
            if (scart_chsw) begin
                sel.l = snd2 ? SRC_SCART_R : SRC_SCART_L;
                sel.r = snd2 ? SRC_SCART_R : SRC_SCART_L;
            end else begin
                sel = '{l: SRC_SCART_L, r: SRC_SCART_R};
            end
        end else if (am) begin
            sel = '{l: SRC_AM, r: SRC_AM};
        end else if (bypass) begin
            sel = '{l: SRC_RAW_L, r: SRC_RAW_R};
        end else begin
            case (eff_mode)
                MODE_STEREO: sel = '{l: SRC_MTX_L, r: SRC_MTX_R};
                MODE_DUAL: begin
                    sel.l = snd2 ? SRC_SND2 : SRC_SND1;
                    sel.r = snd2 ? SRC_SND2 : SRC_SND1;
                end
                default:     sel = '{l: SRC_SND1, r: SRC_SND1};
            endcase
        end
    end
endmodule

// File: rtl/audio_route_scart.sv
module audio_route_scart
    import audio_route_pkg::*;
(
    input  logic              am,
    input  logic              bypass,
    input  logic [MODE_W-1:0] eff_mode,
    input  logic [1:0]        scart_map,
    output pair_t             sel
);
    always_comb begin
        sel = '{l: SRC_SND1, r: SRC_SND1};
        if (am) begin
            sel = '{l: SRC_AM, r: SRC_AM};
        end else if (bypass) begin
            sel = '{l: SRC_RAW_L, r: SRC_RAW_R};
        end else begin
            case (eff_mode)
                MODE_STEREO: sel = '{l: SRC_MTX_L, r: SRC_MTX_R};
                MODE_DUAL: begin
                    sel.l = scart_map[0] ? SRC_SND2 : SRC_SND1;
                    sel.r = scart_map[1] ? SRC_SND1 : SRC_SND2;
                end
                default:     sel = '{l: SRC_SND1, r: SRC_SND1};
            endcase
        end
    end
endmodule

// File: rtl/audio_route_ctrl.sv
module audio_route_ctrl
    import audio_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_mute_all_n,
    input  logic              cfg_spk_on,
    input  logic              cfg_scart_on,
    input  logic              cfg_spk_snd2,
    input  logic              cfg_hp_snd2,
    input  logic              cfg_scart_play,
    input  logic              cfg_scart_chsw,
    input  logic              cfg_am,
    input  logic              cfg_bypass,
    input  logic [1:0]        cfg_matrix,
    input  logic [1:0]        cfg_scart_map,
    input  logic [1:0]        id_status,
    output logic [SEL_W-1:0]  spk_l_sel,
    output logic [SEL_W-1:0]  spk_r_sel,
    output logic [SEL_W-1:0]  hp_l_sel,
    output logic [SEL_W-1:0]  hp_r_sel,
    output logic [SEL_W-1:0]  scart_l_sel,
    output logic [SEL_W-1:0]  scart_r_sel,
    output logic              spk_live,
    output logic              hp_live,
    output logic              scart_live
);
    state_t              st_d, st_q;
    cfg_t                cfg_in, cfg_nx;
    logic [MODE_W-1:0]   eff_mode;
    logic [NUM_PROG-1:0] snd2_v;
    pair_t               prog_sel [NUM_PROG];
    pair_t               sct_sel;

    always_comb begin
        cfg_in = '{
            mute_all_n: cfg_mute_all_n, spk_on: cfg_spk_on,
            scart_on: cfg_scart_on, spk_snd2: cfg_spk_snd2,
            hp_snd2: cfg_hp_snd2, scart_play: cfg_scart_play,
            scart_chsw: cfg_scart_chsw, am: cfg_am, bypass: cfg_bypass,
            matrix: cfg_matrix, scart_map: cfg_scart_map
        };
        cfg_nx = cfg_load ? cfg_in : st_q.cfg;
        snd2_v = {cfg_nx.hp_snd2, cfg_nx.spk_snd2};
    end

    audio_route_mode u_mode (
        .matrix    (cfg_nx.matrix),
        .id_status (id_status),
        .eff_mode  (eff_mode)
    );

    for (genvar g = 0; g < NUM_PROG; g++) begin : g_prog
        audio_route_prog u_prog (
            .scart_play (cfg_nx.scart_play),
            .scart_chsw (cfg_nx.scart_chsw),
            .am         (cfg_nx.am),
            .bypass     (cfg_nx.bypass),
            .eff_mode   (eff_mode),
            .snd2       (snd2_v[g]),
            .sel        (prog_sel[g])
        );
    end

    audio_route_scart u_scart (
        .am        (cfg_nx.am),
        .bypass    (cfg_nx.bypass),
        .eff_mode  (eff_mode),
        .scart_map (cfg_nx.scart_map),
        .sel       (sct_sel)
    );

    always_comb begin
        st_d              = st_q;
        st_d.cfg          = cfg_nx;
        st_d.out.spk      = prog_sel[0];
        st_d.out.hp       = prog_sel[1];
        st_d.out.sct      = sct_sel;
        st_d.out.hp_live  = cfg_nx.mute_all_n;
        st_d.out.spk_live = cfg_nx.mute_all_n & cfg_nx.spk_on;
        st_d.out.sct_live = cfg_nx.mute_all_n & cfg_nx.scart_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= CFG_RESET;
            st_q.out <= ROUTE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign spk_l_sel   = st_q.out.spk.l;
    assign spk_r_sel   = st_q.out.spk.r;
    assign hp_l_sel    = st_q.out.hp.l;
    assign hp_r_sel    = st_q.out.hp.r;
    assign scart_l_sel = st_q.out.sct.l;
    assign scart_r_sel = st_q.out.sct.r;
    assign spk_live    = st_q.out.spk_live;
    assign hp_live     = st_q.out.hp_live;
    assign scart_live  = st_q.out.sct_live;
endmodule

// File: rtl/audio_route_chk.sv
module audio_route_chk
    import audio_route_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic             cfg_mute_all_n,
    input logic             cfg_spk_on,
    input logic             cfg_scart_on,
    input logic             cfg_spk_snd2,
    input logic             cfg_hp_snd2,
    input logic             cfg_scart_play,
    input logic             cfg_scart_chsw,
    input logic             cfg_am,
    input logic             cfg_bypass,
    input logic [1:0]       cfg_matrix,
    input logic [1:0]       cfg_scart_map,
    input logic [1:0]       id_status,
    input logic [SEL_W-1:0] spk_l_sel,
    input logic [SEL_W-1:0] spk_r_sel,
    input logic [SEL_W-1:0] hp_l_sel,
    input logic [SEL_W-1:0] hp_r_sel,
    input logic [SEL_W-1:0] scart_l_sel,
    input logic [SEL_W-1:0] scart_r_sel,
    input logic             spk_live,
    input logic             hp_live,
    input logic             scart_live
);
    AST_MASTER_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load && !cfg_mute_all_n |=> !spk_live && !hp_live && !scart_live); // R1

    AST_SPK_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        spk_live |-> hp_live); // R2

    AST_SCART_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        scart_live |-> hp_live); // R2

    AST_SPK_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load && cfg_mute_all_n && !cfg_spk_on && cfg_scart_on |=> hp_live && !spk_live && scart_live); // R2

    AST_STEREO_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load && cfg_matrix == 2'b01 && !cfg_scart_play && !cfg_am && !cfg_bypass
        |=> spk_l_sel == SRC_MTX_L && hp_r_sel == SRC_MTX_R); // R4

    AST_DUAL_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load && cfg_matrix == 2'b10 && !cfg_scart_play && !cfg_am && !cfg_bypass
        |=> spk_l_sel == ($past(cfg_spk_snd2) ? SRC_SND2 : SRC_SND1)
            && hp_r_sel == ($past(cfg_hp_snd2) ? SRC_SND2 : SRC_SND1)); // R4

    AST_SCART_MAP_01: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load && cfg_matrix == 2'b10 && !cfg_am && !cfg_bypass && cfg_scart_map == 2'b01
        |=> scart_l_sel == SRC_SND2 && scart_r_sel == SRC_SND2); // R6

    AST_PLAYBACK_STEREO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load && cfg_scart_play && !cfg_scart_chsw
        |=> spk_l_sel == SRC_SCART_L && spk_r_sel == SRC_SCART_R); // R7

    AST_AM_OVER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load && cfg_am && !cfg_scart_play
        |=> hp_l_sel == SRC_AM && scart_r_sel == SRC_AM); // R8

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load && $stable(id_status)
        |=> $stable(spk_l_sel) && $stable(hp_r_sel) && $stable(scart_l_sel) && $stable(spk_live)); // R9
endmodule

bind audio_route_ctrl audio_route_chk u_chk (.*);

// File: tb/audio_route_ctrl_bench.sv
module audio_route_ctrl_bench;
    import audio_route_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    cfg_t       c_drv = CFG_RESET;
    logic [1:0] id_status = 2'b00;
    logic [3:0] spk_l_sel, spk_r_sel, hp_l_sel, hp_r_sel, scart_l_sel, scart_r_sel;
    logic       spk_live, hp_live, scart_live;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    audio_route_ctrl u_audio_route_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_mute_all_n(c_drv.mute_all_n), .cfg_spk_on(c_drv.spk_on),
        .cfg_scart_on(c_drv.scart_on), .cfg_spk_snd2(c_drv.spk_snd2),
        .cfg_hp_snd2(c_drv.hp_snd2), .cfg_scart_play(c_drv.scart_play),
        .cfg_scart_chsw(c_drv.scart_chsw), .cfg_am(c_drv.am),
        .cfg_bypass(c_drv.bypass), .cfg_matrix(c_drv.matrix),
        .cfg_scart_map(c_drv.scart_map), .id_status(id_status),
        .spk_l_sel(spk_l_sel), .spk_r_sel(spk_r_sel),
        .hp_l_sel(hp_l_sel), .hp_r_sel(hp_r_sel),
        .scart_l_sel(scart_l_sel), .scart_r_sel(scart_r_sel),
        .spk_live(spk_live), .hp_live(hp_live), .scart_live(scart_live)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_sel(input string req, input int spl, input int spr, input int hpl,
                           input int hpr, input int scl, input int scr);
        chk(req, "spk_l", int'(spk_l_sel), spl);
        chk(req, "spk_r", int'(spk_r_sel), spr);
        chk(req, "hp_l", int'(hp_l_sel), hpl);
        chk(req, "hp_r", int'(hp_r_sel), hpr);
        chk(req, "scart_l", int'(scart_l_sel), scl);
        chk(req, "scart_r", int'(scart_r_sel), scr);
    endtask

    task automatic chk_live(input string req, input int s, input int h, input int t);
        chk(req, "spk_live", int'(spk_live), s);
        chk(req, "hp_live", int'(hp_live), h);
        chk(req, "scart_live", int'(scart_live), t);
    endtask

    function automatic cfg_t base_cfg();
        cfg_t c = '0;
        c.mute_all_n = 1'b1;
        c.spk_on     = 1'b1;
        c.scart_on   = 1'b1;
        return c;
    endfunction

    task automatic load(input cfg_t c);
        @(negedge clk);
        c_drv    = c;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic t_reset();
        chk_live("R10", 0, 0, 0);
        chk_sel("R10", 6, 6, 6, 6, 6, 6);
    endtask

    task automatic t_mutes();
        cfg_t c = base_cfg();
        c.mute_all_n = 1'b0;
        load(c);
        chk_live("R1", 0, 0, 0);
        c.mute_all_n = 1'b1; c.spk_on = 1'b0; c.scart_on = 1'b0;
        load(c);
        chk_live("R2", 0, 1, 0);
        c.spk_on = 1'b1;
        load(c);
        chk_live("R2", 1, 1, 0);
        c.spk_on = 1'b0; c.scart_on = 1'b1;
        load(c);
        chk_live("R2", 0, 1, 1);
    endtask

    task automatic t_forced_modes();
        cfg_t c = base_cfg();
        c.spk_snd2 = 1'b1;
        c.matrix = 2'b00;
        load(c);
        chk_sel("R4", 0, 0, 0, 0, 0, 0);
        c.matrix = 2'b01;
        load(c);
        chk_sel("R4", 2, 3, 2, 3, 2, 3);
        c.matrix = 2'b10; c.hp_snd2 = 1'b0;
        load(c);
        chk_sel("R4", 1, 1, 0, 0, 0, 1);
        c.spk_snd2 = 1'b0; c.hp_snd2 = 1'b1;
        load(c);
        chk_sel("R4", 0, 0, 1, 1, 0, 1);
    endtask

    task automatic t_auto();
        cfg_t c = base_cfg();
        c.matrix = 2'b11; c.spk_snd2 = 1'b1;
        @(negedge clk);
        id_status = 2'b10;
        load(c);
        chk_sel("R5", 1, 1, 0, 0, 0, 1);
        id_status = 2'b01;
        @(negedge clk);
        chk_sel("R5", 2, 3, 2, 3, 2, 3);
        id_status = 2'b00;
        @(negedge clk);
        chk_sel("R5", 0, 0, 0, 0, 0, 0);
        id_status = 2'b11;
        @(negedge clk);
        chk_sel("R5", 0, 0, 0, 0, 0, 0);
        id_status = 2'b00;
    endtask

    task automatic t_scart_map();
        cfg_t c = base_cfg();
        int expl[4] = '{0, 1, 0, 1};
        int expr[4] = '{1, 1, 0, 0};
        c.matrix = 2'b10;
        for (int m = 0; m < 4; m++) begin
            c.scart_map = 2'(m);
            load(c);
            chk("R6", "scart_l", int'(scart_l_sel), expl[m]);
            chk("R6", "scart_r", int'(scart_r_sel), expr[m]);
        end
        c.matrix = 2'b01; c.scart_map = 2'b01;
        load(c);
        chk("R6", "scart_l stereo", int'(scart_l_sel), 2);
        chk("R6", "scart_r stereo", int'(scart_r_sel), 3);
    endtask

    task automatic t_playback();
        cfg_t c = base_cfg();
        c.scart_play = 1'b1; c.matrix = 2'b01;
        load(c);
        chk_sel("R7", 7, 8, 7, 8, 2, 3);
        c.scart_chsw = 1'b1; c.spk_snd2 = 1'b1; c.hp_snd2 = 1'b0;
        load(c);
        chk_sel("R7", 8, 8, 7, 7, 2, 3);
        c.scart_chsw = 1'b0; c.am = 1'b1;
        load(c);
        chk_sel("R3", 7, 8, 7, 8, 6, 6);
    endtask

    task automatic t_am_bypass();
        cfg_t c = base_cfg();
        c.am = 1'b1; c.bypass = 1'b1; c.matrix = 2'b10;
        load(c);
        chk_sel("R8", 6, 6, 6, 6, 6, 6);
        c.am = 1'b0; c.spk_snd2 = 1'b1;
        load(c);
        chk_sel("R8", 4, 5, 4, 5, 4, 5);
    endtask

    task automatic t_timing();
        cfg_t c = base_cfg();
        c.matrix = 2'b01;
        load(c);
        c.am = 1'b1;
        @(negedge clk);
        c_drv = c;
        cfg_load = 1'b1;
        #2;
        chk("R9", "before edge", int'(spk_l_sel), 2);
        @(negedge clk);
        cfg_load = 1'b0;
        chk("R9", "after one edge", int'(spk_l_sel), 6);
        c_drv = base_cfg();
        c_drv.mute_all_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "ignored sel", int'(spk_l_sel), 6);
        chk("R9", "ignored live", int'(hp_live), 1);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mutes();
        t_forced_modes();
        t_auto();
        t_scart_map();
        t_playback();
        t_am_bypass();
        t_timing();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule